// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block is the digital side of an 8-bit successive-approximation converter with a multiplexed analog input. A host selects the block by pulling `cs_n` low. It then clocks in a start bit and a four-bit channel address on `di`. The block latches the channel and spends one clock period letting the selected input settle. It then runs one comparison per clock against an external comparator, which is modelled here as the single input bit `comp_i`.

The serial output `dout_o` is qualified by `dout_oe_o`, which stands in for a tri-state driver. Each result bit is presented on a falling clock edge as soon as it is resolved, most significant bit first. After the conversion the result is copied into a readback shifter and replayed least significant bit first. Holding `se_i` high freezes that replay. After the last bit the line holds low until `cs_n` returns high. Input sampling stops before the output driver turns on, so `di` and `dout_o` can share one wire.

Top module: `sar_serial_seq`

## Requirements
- R1: While `rst` or `cs_n` is high at a rising edge, the block returns to its idle state. In that state `sars_o` is 0, `trial_o` is 0, `ch_sel_o` is 0, `ch_single_o` is 0 and `dout_oe_o` is 0.
- R2: While addressing, `di` is sampled on rising edges and zeros before the first 1 are ignored. That first 1 is the start bit. The next four bits are single-ended, odd, select-high and select-low, in that order. From the edge that samples select-low, `ch_single_o` shows the single-ended bit and `ch_sel_o` = {odd, select-high, select-low}.
- R3: `sars_o` goes high on the rising edge that samples the last address bit. On the following falling edge `dout_oe_o` rises with `dout_o` = 0. `dout_o` then stays 0 until the first result bit is due. `trial_o` becomes 0x80 one rising edge later.
- R4: On each comparison edge the bit under trial is kept if `comp_i` is 1 and cleared if it is 0. The next lower bit is then set to 1 and all bits below it are 0. After eight comparisons `trial_o` holds the result.
- R5: The bit resolved on comparison edge k (k = 1 is the MSB) appears on `dout_o` at the falling edge that follows it.
- R6: `sars_o` falls on the eighth comparison edge, nine rising edges after it rose.
- R7: One rising edge after `sars_o` falls, the result is loaded for readback. `dout_o` keeps showing bit 0. On each later rising edge with `se_i` low the next higher bit is shown. While `se_i` is high the shown bit holds.
- R8: On the rising edge with `se_i` low after bit 7 has been shown, `dout_o` goes to 0. It stays 0, with `dout_oe_o` high, until deselect.
- R9: After the last address bit, `di` has no effect on any output.
- R10: `dout_oe_o` drops as soon as `cs_n` goes high, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high clears the block |
| di | input | 1 | Serial start bit and address |
| comp_i | input | 1 | Comparator result: 1 when the input is above the trial level |
| se_i | input | 1 | Readback enable: high holds, low shifts |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output driver enable for `dout_o` |
| sars_o | output | 1 | Conversion in progress |
| trial_o | output | NBITS | Current trial code, and the result when the conversion is done |
| ch_sel_o | output | 3 | Selected channel {odd, select-high, select-low} |
| ch_single_o | output | 1 | Single-ended (1) or differential (0) selection |

## Verification
A fault in the address shifter shows up within one edge of the last address bit, either as a wrong channel or as `sars_o` rising at the wrong time. A fault in the trial register shows up on `trial_o` at the next comparison edge. Because the comparator model follows the target code, such a fault also shows on `dout_o` half a clock later. A fault in the readback counter or shifter appears as a wrong bit or an early low level in the LSB-first stream. A fault in the output stage's clear appears as a driven line after `cs_n` rises.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    // start bit plus four address bits
    localparam int ADDR_W = 5;

    typedef enum logic [2:0] {
        S_ADDR   = 3'd0,
        S_SETTLE = 3'd1,
        S_CONV   = 3'd2,
        S_HOLD   = 3'd3,
        S_READ   = 3'd4,
        S_DONE   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic       single;
        logic       odd;
        logic [1:0] sel;
    } chan_addr_t;

    function automatic logic [2:0] chan_index(chan_addr_t a);
        return {a.odd, a.sel};
    endfunction

endpackage

// File: rtl/sar_addr_rx.sv
`timescale 1ns/1ps
module sar_addr_rx
    import sar_seq_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       en,
    input  logic       di,
    output logic       last_o,
    output chan_addr_t addr_o
);
    logic [ADDR_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (clr)
            sr <= '0;
        else if (en)
            sr <= {sr[ADDR_W-2:0], di};
    end

    // the first 1 shifted in is the start bit; one slot short of the top means this di is the last field bit
    assign last_o = en & sr[ADDR_W-2];
    assign addr_o = chan_addr_t'(sr[ADDR_W-2:0]);

    p_start_top_r2: assert property (@(posedge clk) disable iff (clr)
        last_o |=> sr[ADDR_W-1]);

endmodule

// File: rtl/sar_approx.sv
`timescale 1ns/1ps
module sar_approx #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             start,
    input  logic             step,
    input  logic             comp,
    output logic [NBITS-1:0] trial_o,
    output logic             bit_o,
    output logic             first_o,
    output logic             last_o
);
    localparam logic [NBITS-1:0] TOP = {1'b1, {(NBITS-1){1'b0}}};

    logic [NBITS-1:0] trial, pos;
    logic             bit_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            trial <= '0;
            pos   <= '0;
            bit_q <= 1'b0;
        end else if (start) begin
            trial <= TOP;
            pos   <= TOP;
        end else if (step) begin
            trial <= (trial & ~pos) | (comp ? pos : '0) | (pos >> 1);
            pos   <= pos >> 1;
            bit_q <= comp;
        end
    end

    assign trial_o = trial;
    assign bit_o   = bit_q;
    assign first_o = pos[NBITS-1];
    assign last_o  = pos[0];

    p_pos_onehot_r4: assert property (@(posedge clk) disable iff (clr)
        $onehot0(pos));
    p_keep_rule_r4: assert property (@(posedge clk) disable iff (clr)
        step |=> ((trial & $past(pos)) == ($past(comp) ? $past(pos) : '0)));

endmodule

// File: rtl/sar_readback.sv
`timescale 1ns/1ps
module sar_readback #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic             shift,
    input  logic [NBITS-1:0] din,
    output logic             bit_o,
    output logic             last_o
);
    localparam int CW = $clog2(NBITS);
    localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

    logic [NBITS-1:0] sr;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= din;
            cnt <= '0;
        end else if (shift) begin
            sr  <= sr >> 1;
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_o  = sr[0];
    assign last_o = (cnt == LAST);

    p_shift_count_r7: assert property (@(posedge clk) disable iff (clr)
        (shift && !load) |=> (cnt == CW'($past(cnt) + 1'b1)));

endmodule

// File: rtl/sar_serial_seq.sv
`timescale 1ns/1ps
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS  = 8,
    parameter bit HAS_SE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             di,
    input  logic             comp_i,
    input  logic             se_i,
    output logic             dout_o,
    output logic             dout_oe_o,
    output logic             sars_o,
    output logic [NBITS-1:0] trial_o,
    output logic [2:0]       ch_sel_o,
    output logic             ch_single_o
);
    logic       clr;
    seq_state_e st, st_nx;
    logic       se_eff;
    logic       addr_last, sar_start, sar_step, sar_bit, sar_first, sar_last;
    logic       rb_load, rb_shift, rb_bit, rb_last;
    chan_addr_t addr;
    logic       oe_q, dq_q, oe_nx, dq_nx;

    assign clr = rst | cs_n;

    generate
        if (HAS_SE) begin : g_se_pin
            assign se_eff = se_i;
        end else begin : g_auto_replay
            assign se_eff = 1'b0;
        end
    endgenerate

    sar_addr_rx u_addr (
        .clk    (clk),
        .clr    (clr),
        .en     (st == S_ADDR),
        .di     (di),
        .last_o (addr_last),
        .addr_o (addr)
    );

    sar_approx #(.NBITS(NBITS)) u_sar (
        .clk     (clk),
        .clr     (clr),
        .start   (sar_start),
        .step    (sar_step),
        .comp    (comp_i),
        .trial_o (trial_o),
        .bit_o   (sar_bit),
        .first_o (sar_first),
        .last_o  (sar_last)
    );

    sar_readback #(.NBITS(NBITS)) u_rb (
        .clk    (clk),
        .clr    (clr),
        .load   (rb_load),
        .shift  (rb_shift),
        .din    (trial_o),
        .bit_o  (rb_bit),
        .last_o (rb_last)
    );

    always_comb begin
        st_nx     = st;
        sar_start = 1'b0;
        sar_step  = 1'b0;
        rb_load   = 1'b0;
        rb_shift  = 1'b0;
        unique case (st)
            S_ADDR:   if (addr_last) st_nx = S_SETTLE;
            S_SETTLE: begin sar_start = 1'b1; st_nx = S_CONV; end
            S_CONV: begin
                sar_step = 1'b1;
                if (sar_last) st_nx = S_HOLD;
            end
            S_HOLD:   begin rb_load = 1'b1; st_nx = S_READ; end
            S_READ: if (!se_eff) begin
                if (rb_last) st_nx = S_DONE;
                else         rb_shift = 1'b1;
            end
            S_DONE:   st_nx = S_DONE;
            default:  st_nx = S_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) st <= S_ADDR;
        else     st <= st_nx;
    end

    // data for the next falling edge
    always_comb begin
        oe_nx = 1'b1;
        dq_nx = 1'b0;
        unique case (st)
            S_ADDR:  oe_nx = 1'b0;
            S_CONV:  dq_nx = sar_first ? 1'b0 : sar_bit;
            S_HOLD:  dq_nx = sar_bit;
            S_READ:  dq_nx = rb_bit;
            default: dq_nx = 1'b0;
        endcase
    end

    always_ff @(negedge clk) begin
        if (clr) begin
            oe_q <= 1'b0;
            dq_q <= 1'b0;
        end else begin
            oe_q <= oe_nx;
            dq_q <= dq_nx;
        end
    end

    assign dout_oe_o   = oe_q & ~cs_n;
    assign dout_o      = dq_q & dout_oe_o;
    assign sars_o      = (st == S_SETTLE) || (st == S_CONV);
    assign ch_sel_o    = (st == S_ADDR) ? 3'b000 : chan_index(addr);
    assign ch_single_o = (st != S_ADDR) && addr.single;

    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!sars_o && trial_o == '0 && ch_sel_o == 3'b000));
    p_lead_zero_r3: assert property (@(posedge clk) disable iff (clr)
        (st == S_SETTLE) |-> (oe_q && !dq_q));
    p_sars_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sars_o) |-> (st == S_HOLD || st == S_ADDR));
    p_chan_frozen_r9: assert property (@(posedge clk) disable iff (clr)
        (st != S_ADDR) |=> $stable(ch_sel_o) && $stable(ch_single_o));

endmodule

// File: tb/sar_serial_seq_bench.sv
`timescale 1ns/1ps
module sar_serial_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       di = 1'b0;
    logic       se = 1'b0;
    logic       comp;
    logic       dout, dout_oe, sars, ch_single;
    logic [7:0] trial;
    logic [2:0] ch_sel;
    logic [7:0] tgt = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    int         m_lat = 0, m_started = 0, m_n = 0, m_e = 0, m_rd = 0, m_done = 0;
    logic [3:0] m_fields = 4'h0;

    always #5 clk = ~clk;

    // comparator: high when the analog level (target) is at or above the trial level
    assign comp = (tgt >= trial);

    sar_serial_seq u_sar_serial_seq (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .di          (di),
        .comp_i      (comp),
        .se_i        (se),
        .dout_o      (dout),
        .dout_oe_o   (dout_oe),
        .sars_o      (sars),
        .trial_o     (trial),
        .ch_sel_o    (ch_sel),
        .ch_single_o (ch_single)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst || cs_n) begin
            m_lat = 0; m_started = 0; m_n = 0; m_e = 0; m_rd = 0; m_done = 0; m_fields = 4'h0;
        end else if (m_lat == 0) begin
            if (m_started == 0) begin
                if (di) begin m_started = 1; m_n = 0; end
            end else begin
                m_fields = {m_fields[2:0], di};
                m_n++;
                if (m_n == 4) begin m_lat = 1; m_e = 0; end
            end
        end else begin
            m_e++;
            if (m_e >= 11 && m_done == 0 && !se) begin
                if (m_rd == 7) m_done = 1;
                else           m_rd++;
            end
        end
    end

    // compare late in each cycle, after the falling-edge update
    always @(negedge clk) begin
        logic [7:0] e_trial;
        logic       e_d, e_oe, e_sars;
        string      dreq;
        #4;
        if (!rst) begin
            e_sars = (m_lat != 0) && (m_e <= 8);
            e_oe   = (m_lat != 0) && !cs_n;
            if (m_lat == 0 || m_e == 0) e_trial = 8'h00;
            else if (m_e >= 9)          e_trial = tgt;
            else e_trial = (tgt & ~(8'hFF >> (m_e - 1))) | (8'h80 >> (m_e - 1));
            if (m_e <= 1)       begin e_d = 1'b0; dreq = "R3"; end
            else if (m_e <= 9)  begin e_d = tgt[9 - m_e]; dreq = "R5"; end
            else if (m_done==0) begin e_d = tgt[m_rd]; dreq = "R7"; end
            else                begin e_d = 1'b0; dreq = "R8"; end
            chk(sars == e_sars, (m_e == 9) ? "R6" : "R3", sars, e_sars);
            chk(dout_oe == e_oe, cs_n ? "R10" : "R3", dout_oe, e_oe);
            chk(trial == e_trial, "R4", trial, e_trial);
            chk(ch_sel == ((m_lat != 0) ? m_fields[2:0] : 3'b000), "R2", ch_sel,
                (m_lat != 0) ? m_fields[2:0] : 3'b000);
            chk(ch_single == ((m_lat != 0) && m_fields[3]), "R9", ch_single,
                (m_lat != 0) && m_fields[3]);
            if (e_oe) chk(dout == e_d, dreq, dout, e_d);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    // one transaction: leading zeros, start, {single, odd, sel1, sel0}, then run cycles
    task automatic convert(input logic [7:0] t, input int zeros, input logic [3:0] f,
                           input int run, input int se_from, input int se_len,
                           input bit abort);
        step();
        tgt = t; cs_n = 1'b0; se = 1'b0; di = 1'b0;
        for (int i = 0; i < zeros; i++) step();
        di = 1'b1; step();
        for (int i = 3; i >= 0; i--) begin di = f[i]; step(); end
        for (int i = 0; i < run; i++) begin
            di = 1'($urandom);   // R9: ignored after the address
            se = (i >= se_from && i < se_from + se_len);
            step();
        end
        cs_n = 1'b1; di = 1'b0; se = 1'b0;
        if (abort) begin
            #1 chk(dout_oe == 1'b0, "R10", dout_oe, 0);
        end
        step(); step();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step(); step();
        // R1: idle with select high
        chk(!sars && !dout_oe && trial == 8'h00 && ch_sel == 3'b000 && !ch_single,
            "R1", {sars, dout_oe, trial}, 0);
        convert(8'hA5, 0, 4'b1011, 24, 0, 0, 1'b0);
        convert(8'h00, 2, 4'b0110, 22, 0, 0, 1'b0);
        convert(8'hFF, 1, 4'b1100, 28, 9, 5, 1'b0);   // R7: hold with se high
        convert(8'h5A, 0, 4'b0001, 5, 0, 0, 1'b1);    // R10: abort mid-conversion
        convert(8'h3C, 3, 4'b1111, 30, 12, 3, 1'b0);
        convert(8'h01, 0, 4'b0010, 22, 0, 0, 1'b0);
        convert(8'h80, 1, 4'b1000, 23, 0, 0, 1'b0);
        // R1: also cleared by reset while selected
        step(); cs_n = 1'b0; di = 1'b1;
        for (int i = 0; i < 8; i++) begin di = (i < 5); step(); end
        rst = 1'b1; step(); step();
        chk(!sars && trial == 8'h00 && !dout_oe, "R1", {sars, trial}, 0);
        rst = 1'b0; cs_n = 1'b1; di = 1'b0;
        step(); step();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule